// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block connects a stereo PCM datapath to a three-wire serial audio link made of a bit clock, a word-select line and a data line. Left and right words share the data line, and the word-select level tells them apart. The block has a receiver and a transmitter. The receiver turns the incoming serial data into a pair of 24-bit sample registers and raises a one-cycle valid strobe for each complete stereo pair. The transmitter takes a pair of 24-bit samples and serializes them onto the outgoing data line. The far end is the clock master, so the bit clock and word-select arrive as inputs. The block samples them with its own system clock, which must run several times faster than the bit clock.

A static 3-bit format input selects the framing. It offers plain I2S, MSB-justified framing, LSB-justified framing at 16, 18 or 20 bits, and three mixed settings. In a mixed setting the output is MSB-justified while the input is LSB-justified at the chosen width. Each channel occupies a slot of `SLOT_BITS` bit-clock periods. The slot must be longer than 24 bits. Samples are carried right-aligned and in two's complement on the parallel side.

Top module: `sap_top`

## Requirements
- R1: While reset is asserted and immediately after it is released, `rx_valid`, `rx_left`, `rx_right` and `sd_out` are all zero.
- R2: With `fmt_sel`=0 (I2S), the receiver takes the 24 bits MSB first, starting one bit-clock period after each word-select change. Word-select low marks the left channel. Bits received after those 24 have no effect.
- R3: With `fmt_sel`=1 (MSB-justified), the receiver takes 20 bits MSB first, the first of them sampled at the first rising bit-clock edge after the word-select change. Word-select high marks the left channel. Bits received after those 20 have no effect.
- R4: With `fmt_sel` set to 2, 3 or 4 (LSB-justified at 16, 18 or 20 bits), the receiver takes the last N bits before each word-select change as the word, with its LSB last. Earlier bits in the slot have no effect. Word-select high marks the left channel.
- R5: Every received word is sign-extended from its format width to 24 bits.
- R6: `rx_valid` is a single-cycle pulse, raised once for each left word that is followed by a right word. It rises after the right word has completed, which is detected at the next word-select change. `rx_left` and `rx_right` change only in the cycle in which `rx_valid` rises.
- R7: With `fmt_sel`=0, the transmitter drives 0 in the first bit period of each slot, then bits 23 down to 0 of the sample, then 0 for the rest of the slot. Word-select low marks the left channel.
- R8: With `fmt_sel`=1, the transmitter drives bits 19 down to 0 of the sample, starting in the bit period in which word-select changes, then drives 0 for the rest of the slot.
- R9: With `fmt_sel` set to 2, 3 or 4, the transmitter drives bits N-1 down to 0 of the sample in the last N bit periods of the slot. All earlier bits of the slot carry copies of bit N-1.
- R10: With `fmt_sel` set to 5, 6 or 7, the receiver behaves as LSB-justified at 16, 18 or 20 bits respectively, and the transmitter behaves as MSB-justified at 20 bits.
- R11: Both transmit samples are captured at the word-select change that starts a left slot. Changes to `tx_left` or `tx_right` after that point do not affect the stereo pair that is already being sent.
- R12: `sd_out` changes only in the cycle that follows a detected falling bit-clock edge, so it is stable whenever the bit clock rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 3 | Framing select, static during operation |
| sclk_in | input | 1 | Serial bit clock from the link master |
| ws_in | input | 1 | Word-select from the link master |
| sd_in | input | 1 | Serial data into the receiver |
| tx_left | input | 24 | Left sample to transmit |
| tx_right | input | 24 | Right sample to transmit |
| sd_out | output | 1 | Serial data out of the transmitter |
| rx_left | output | 24 | Last received left sample |
| rx_right | output | 24 | Last received right sample |
| rx_valid | output | 1 | One-cycle strobe for a new received pair |

## Verification
The bench fills the unused bit periods of each slot with random junk. A receiver that kept shifting past the word in the MSB-first framings would then return a shifted value, and one that used the leading bits in LSB-justified framing would return the wrong upper bits. Each format starts with the most negative and the most positive value at its width. A missing sign extension or a width off by one shows up as a wrong top bit or a scaled result. The bench also changes the transmit inputs in the middle of every left slot. A transmitter that sampled its inputs late would then send a mix of two pairs. The I2S one-bit delay is checked in both directions: if it were misplaced, every received word would be shifted by one bit and every transmitted slot would be misaligned.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SMP_W   = 24;
    localparam int WID_W   = $clog2(SMP_W + 1);
    localparam int MSBJ_W  = 20;

    typedef logic [SMP_W-1:0] sample_t;

    typedef enum logic [2:0] {
        FMT_I2S   = 3'd0,
        FMT_MSBJ  = 3'd1,
        FMT_LSB16 = 3'd2,
        FMT_LSB18 = 3'd3,
        FMT_LSB20 = 3'd4,
        FMT_MIX16 = 3'd5,
        FMT_MIX18 = 3'd6,
        FMT_MIX20 = 3'd7
    } fmt_e;

    typedef enum logic [1:0] {
        FR_I2S = 2'd0,
        FR_MSB = 2'd1,
        FR_LSB = 2'd2
    } frame_e;

    typedef struct packed {
        frame_e            rx_fr;
        logic [WID_W-1:0]  rx_w;
        frame_e            tx_fr;
        logic [WID_W-1:0]  tx_w;
    } cfg_t;

    function automatic cfg_t decode_fmt(fmt_e f);
        cfg_t c;
        case (f)
            FMT_MSBJ:  c = '{FR_MSB, WID_W'(MSBJ_W), FR_MSB, WID_W'(MSBJ_W)};
            FMT_LSB16: c = '{FR_LSB, WID_W'(16),     FR_LSB, WID_W'(16)};
            FMT_LSB18: c = '{FR_LSB, WID_W'(18),     FR_LSB, WID_W'(18)};
            FMT_LSB20: c = '{FR_LSB, WID_W'(20),     FR_LSB, WID_W'(20)};
            FMT_MIX16: c = '{FR_LSB, WID_W'(16),     FR_MSB, WID_W'(MSBJ_W)};
            FMT_MIX18: c = '{FR_LSB, WID_W'(18),     FR_MSB, WID_W'(MSBJ_W)};
            FMT_MIX20: c = '{FR_LSB, WID_W'(20),     FR_MSB, WID_W'(MSBJ_W)};
            default:   c = '{FR_I2S, WID_W'(SMP_W),  FR_I2S, WID_W'(SMP_W)};
        endcase
        return c;
    endfunction

    // Copy bit w-1 into every position above it.
    function automatic sample_t sext(sample_t v, logic [WID_W-1:0] w);
        sample_t r;
        for (int i = 0; i < SMP_W; i++) begin
            r[i] = (i < int'(w)) ? v[i] : v[w - 1'b1];
        end
        return r;
    endfunction

    // The left channel is marked by word-select low in I2S and by word-select high otherwise.
    function automatic logic left_of(frame_e fr, logic ws);
        return (fr == FR_I2S) ? ~ws : ws;
    endfunction

endpackage

// File: rtl/sap_edge.sv
module sap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic rise,
    output logic fall,
    output logic ws,
    output logic sd
);

    typedef struct packed {
        logic sclk;
        logic sclk_old;
        logic ws;
        logic sd;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d          = q;
        d.sclk     = sclk_in;
        d.sclk_old = q.sclk;
        d.ws       = ws_in;
        d.sd       = sd_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise = q.sclk & ~q.sclk_old;
    assign fall = ~q.sclk & q.sclk_old;
    assign ws   = q.ws;
    assign sd   = q.sd;

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  frame_e            rx_fr,
    input  logic [WID_W-1:0]  rx_w,
    input  logic              rise,
    input  logic              ws,
    input  logic              sd,
    output sample_t           out_left,
    output sample_t           out_right,
    output logic              out_valid
);

    typedef struct packed {
        logic              ws_last;
        logic [1:0]        prime;
        logic              chan_prev;
        logic              started;
        sample_t           sreg;
        logic [WID_W-1:0]  nbits;
        sample_t           stage;
        logic              left_ok;
        sample_t           out_l;
        sample_t           out_r;
        logic              valid;
    } rx_t;

    rx_t     q, d;
    logic    chan;
    sample_t word;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        // In I2S the data bit belongs to the word-select level seen one bit earlier.
        chan    = (rx_fr == FR_I2S) ? q.ws_last : ws;
        word    = sext(q.sreg, rx_w);
        if (rise) begin
            d.ws_last = ws;
            if (q.prime != 2'd2) d.prime = q.prime + 2'd1;
            if (q.prime != 2'd0) begin
                d.chan_prev = chan;
                if (q.prime == 2'd2 && chan != q.chan_prev) begin
                    if (q.started) begin
                        if (left_of(rx_fr, q.chan_prev)) begin
                            d.stage   = word;
                            d.left_ok = 1'b1;
                        end else if (q.left_ok) begin
                            d.out_l   = q.stage;
                            d.out_r   = word;
                            d.valid   = 1'b1;
                            d.left_ok = 1'b0;
                        end
                    end
                    d.started = 1'b1;
                    d.sreg    = {{(SMP_W-1){1'b0}}, sd};
                    d.nbits   = WID_W'(1);
                end else if (rx_fr == FR_LSB || q.nbits < rx_w) begin
                    d.sreg = {q.sreg[SMP_W-2:0], sd};
                    if (q.nbits != WID_W'(SMP_W)) d.nbits = q.nbits + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_left  = q.out_l;
    assign out_right = q.out_r;
    assign out_valid = q.valid;

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_e            tx_fr,
    input  logic [WID_W-1:0]  tx_w,
    input  logic              fall,
    input  logic              ws,
    input  sample_t           tx_left,
    input  sample_t           tx_right,
    output logic              sd_out
);

    localparam int POS_W = $clog2(SLOT_BITS + 1);
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(SLOT_BITS);

    typedef struct packed {
        logic              primed;
        logic              ws_last;
        logic [POS_W-1:0]  pos;
        sample_t           hold_l;
        sample_t           hold_r;
        logic              sd;
    } tx_t;

    tx_t     q, d;
    sample_t word;
    int      p_i, w_i, b_i;

    always_comb begin
        d    = q;
        word = '0;
        p_i  = 0;
        w_i  = 0;
        b_i  = 0;
        if (fall) begin
            d.ws_last = ws;
            if (!q.primed) begin
                d.primed = 1'b1;
                d.pos    = POS_MAX;
            end else if (ws != q.ws_last) begin
                d.pos = '0;
                if (left_of(tx_fr, ws)) begin
                    d.hold_l = tx_left;
                    d.hold_r = tx_right;
                end
            end else if (q.pos != POS_MAX) begin
                d.pos = q.pos + 1'b1;
            end
            word = left_of(tx_fr, ws) ? d.hold_l : d.hold_r;
            p_i  = int'(d.pos);
            w_i  = int'(tx_w);
            b_i  = SLOT_BITS - 1 - p_i;
            d.sd = 1'b0;
            case (tx_fr)
                FR_I2S: if (p_i >= 1 && p_i <= SMP_W) d.sd = word[SMP_W - p_i];
                FR_MSB: if (p_i < w_i) d.sd = word[w_i - 1 - p_i];
                default: if (p_i < SLOT_BITS) d.sd = (b_i < w_i) ? word[b_i] : word[w_i - 1];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd_out = q.sd;

endmodule

// File: rtl/sap_top.sv
module sap_top
    import sap_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fmt_sel,
    input  logic             sclk_in,
    input  logic             ws_in,
    input  logic             sd_in,
    input  logic [SMP_W-1:0] tx_left,
    input  logic [SMP_W-1:0] tx_right,
    output logic             sd_out,
    output logic [SMP_W-1:0] rx_left,
    output logic [SMP_W-1:0] rx_right,
    output logic             rx_valid
);

    cfg_t cfg;
    logic edge_rise, edge_fall, ws_s, sd_s;

    assign cfg = decode_fmt(fmt_e'(fmt_sel));

    sap_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .ws_in   (ws_in),
        .sd_in   (sd_in),
        .rise    (edge_rise),
        .fall    (edge_fall),
        .ws      (ws_s),
        .sd      (sd_s)
    );

    sap_rx rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_fr     (cfg.rx_fr),
        .rx_w      (cfg.rx_w),
        .rise      (edge_rise),
        .ws        (ws_s),
        .sd        (sd_s),
        .out_left  (rx_left),
        .out_right (rx_right),
        .out_valid (rx_valid)
    );

    sap_tx #(.SLOT_BITS(SLOT_BITS)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_fr    (cfg.tx_fr),
        .tx_w     (cfg.tx_w),
        .fall     (edge_fall),
        .ws       (ws_s),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sd_out   (sd_out)
    );

endmodule

// File: rtl/sap_checker.sv
module sap_checker
    import sap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] fmt_sel,
    input logic       rise,
    input logic       fall,
    input logic       sd_out,
    input sample_t    rx_left,
    input sample_t    rx_right,
    input logic       rx_valid
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!rx_valid); // R1
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_VALID_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(rise)); // R6

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right))); // R6

    AST_SEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (fmt_sel == 3'd2 || fmt_sel == 3'd5)) |->
        ((rx_left[23:15] == '0 || rx_left[23:15] == '1) &&
         (rx_right[23:15] == '0 || rx_right[23:15] == '1))); // R5

    AST_SEXT_20: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (fmt_sel == 3'd1 || fmt_sel == 3'd4 || fmt_sel == 3'd7)) |->
        ((rx_left[23:19] == '0 || rx_left[23:19] == '1) &&
         (rx_right[23:19] == '0 || rx_right[23:19] == '1))); // R5

    AST_LAUNCH_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> $past(fall)); // R12

endmodule

bind sap_top sap_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_sel  (fmt_sel),
    .rise     (edge_rise),
    .fall     (edge_fall),
    .sd_out   (sd_out),
    .rx_left  (rx_left),
    .rx_right (rx_right),
    .rx_valid (rx_valid)
);

// File: tb/sap_top_tb_top.sv
module sap_top_tb_top;

    localparam int SLOT = 32;
    localparam int NFR  = 5;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic        sclk_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
    logic [23:0] tx_left = '0, tx_right = '0;
    logic        sd_out, rx_valid;
    logic [23:0] rx_left, rx_right;

    int n_chk = 0, n_fail = 0;
    logic [23:0] ll[12], rl[12], tl[12], tr[12];
    logic [23:0] obs_l[12], obs_r[12];
    int n_obs, n_dbl;
    logic vprev;

    always #5 clk = ~clk;

    sap_top #(.SLOT_BITS(SLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
        .tx_left(tx_left), .tx_right(tx_right),
        .sd_out(sd_out), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            n_obs = 0; n_dbl = 0; vprev = 1'b0;
        end else begin
            if (rx_valid) begin
                if (vprev) n_dbl++;
                if (n_obs < 12) begin obs_l[n_obs] = rx_left; obs_r[n_obs] = rx_right; end
                n_obs++;
            end
            vprev = rx_valid;
        end
    end

    function automatic int rx_w(int f);
        case (f) 0: return 24; 1: return 20; 2, 5: return 16; 3, 6: return 18; default: return 20; endcase
    endfunction
    function automatic int tx_w(int f);
        case (f) 0: return 24; 2: return 16; 3: return 18; default: return 20; endcase
    endfunction
    // kind: 0 = I2S, 1 = MSB-justified, 2 = LSB-justified
    function automatic int rx_kind(int f);
        return (f == 0) ? 0 : (f == 1) ? 1 : 2;
    endfunction
    function automatic int tx_kind(int f);
        return (f == 0) ? 0 : (f >= 2 && f <= 4) ? 2 : 1;
    endfunction
    function automatic string rx_req(int f);
        return (f == 0) ? "R2" : (f == 1) ? "R3" : (f <= 4) ? "R4" : "R10";
    endfunction
    function automatic string tx_req(int f);
        return (f == 0) ? "R7" : (f == 1) ? "R8" : (f <= 4) ? "R9" : "R10";
    endfunction

    function automatic logic [23:0] sx(logic [23:0] v, int w);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

    function automatic logic drive_bit(int kind, int w, int p, logic [23:0] v, logic junk);
        int b;
        b = SLOT - 1 - p;
        case (kind)
            0: return (p >= 1 && p <= 24) ? v[24-p] : junk;
            1: return (p < w) ? v[w-1-p] : junk;
            default: return (b < w) ? v[b] : junk;
        endcase
    endfunction

    function automatic logic exp_bit(int kind, int w, int p, logic [23:0] v);
        int b;
        b = SLOT - 1 - p;
        case (kind)
            0: return (p >= 1 && p <= 24) ? v[24-p] : 1'b0;
            1: return (p < w) ? v[w-1-p] : 1'b0;
            default: return (b < w) ? v[b] : v[w-1];
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_frame(int f, int fi, bit check);
        logic [SLOT-1:0] obs, expv;
        logic ws_left, o1, o2, moved;
        ws_left = (f == 0) ? 1'b0 : 1'b1;
        for (int s = 0; s < 2; s++) begin
            moved = 1'b0;
            for (int p = 0; p < SLOT; p++) begin
                sclk_in = 1'b0;
                ws_in   = (s == 0) ? ws_left : ~ws_left;
                sd_in   = drive_bit(rx_kind(f), rx_w(f), p, (s == 0) ? ll[fi] : rl[fi], 1'($urandom));
                if (s == 0 && p == 10) begin
                    tx_left  = tl[fi+1];
                    tx_right = tr[fi+1];
                end
                repeat (HALF) @(negedge clk);
                sclk_in = 1'b1;
                o1 = sd_out;
                obs[SLOT-1-p] = o1;
                expv[SLOT-1-p] = exp_bit(tx_kind(f), tx_w(f), p, (s == 0) ? tl[fi] : tr[fi]);
                repeat (HALF) @(negedge clk);
                o2 = sd_out;
                if (o1 != o2) moved = 1'b1;
            end
            if (check) begin
                chk(obs == expv, tx_req(f), $sformatf("R11 tx fmt%0d frame%0d slot%0d", f, fi, s), obs, expv);
                chk(!moved, "R12", "sd_out moved while bit clock high", 32'(moved), 32'd0);
            end
        end
    endtask

    task automatic run_segment(int f);
        int w, tw;
        w  = rx_w(f);
        tw = tx_w(f);
        for (int i = 0; i < 12; i++) begin
            ll[i] = 24'($urandom); rl[i] = 24'($urandom);
            tl[i] = 24'($urandom); tr[i] = 24'($urandom);
        end
        ll[1] = 24'(1) << (w - 1);
        rl[1] = (24'(1) << (w - 1)) - 24'd1;
        tl[2] = 24'(1) << (tw - 1);
        tr[2] = (24'(1) << (tw - 1)) - 24'd1;
        rst_n = 1'b0; fmt_sel = 3'(f);
        sclk_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
        tx_left = tl[0]; tx_right = tr[0];
        repeat (3) @(negedge clk);
        chk(rx_valid == 1'b0 && rx_left == '0 && rx_right == '0 && sd_out == 1'b0, "R1",
            "outputs in reset", {7'd0, rx_valid, rx_left}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_valid == 1'b0 && sd_out == 1'b0, "R1", "outputs after reset", {30'd0, rx_valid, sd_out}, 32'd0);
        for (int fi = 0; fi <= NFR + 1; fi++) run_frame(f, fi, fi >= 1 && fi <= NFR);
        repeat (4) @(negedge clk);
        chk(n_obs == NFR, "R6", $sformatf("valid count fmt%0d", f), 32'(n_obs), 32'(NFR));
        chk(n_dbl == 0, "R6", "valid longer than one cycle", 32'(n_dbl), 32'd0);
        for (int i = 0; i < NFR && i < n_obs; i++) begin
            chk(obs_l[i] == sx(ll[i+1], w), rx_req(f), $sformatf("rx left fmt%0d frame%0d", f, i + 1),
                obs_l[i], sx(ll[i+1], w));
            chk(obs_r[i] == sx(rl[i+1], w), rx_req(f), $sformatf("rx right fmt%0d frame%0d", f, i + 1),
                obs_r[i], sx(rl[i+1], w));
        end
        if (n_obs > 0)
            chk(obs_l[0][23] == 1'b1, "R5", "most negative word sign", 32'(obs_l[0][23]), 32'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int f = 0; f < 8; f++) run_segment(f);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule